// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that a processor controls through three byte-wide registers on a 2-bit address: a control register, a read-only status register and a data register. Writing the data register while the unit is enabled and idle starts an 8-bit full-duplex transfer. The byte is shifted out on `mosi`, most significant bit first. At the same time `miso` is captured into a receive shifter. The serial clock `sck` follows one of the four polarity and phase modes and runs at a rate chosen by a 2-bit code.

At the end of the eighth bit the received byte becomes the data register's read value and a done flag is raised. The flag can raise an interrupt. A data write that arrives while a byte is still moving is not queued. It raises a collision flag and its byte is lost. Flags are cleared by a two-step sequence: a status read records which flags were set, and the next data-register access clears exactly those flags.

The engine is a three-state machine. `ST_IDLE` waits for a start. `ST_LEAD` is the first half of a bit. `ST_TRAIL` is the second half. The transitions are:
- start: `ST_IDLE` to `ST_LEAD`, taken on an accepted data write.
- capture: `ST_LEAD` to `ST_TRAIL`, taken at the end of the half-period; `miso` is sampled here.
- advance: `ST_TRAIL` to `ST_LEAD`, taken at the end of the half-period when bits remain; the next bit is shifted out.
- finish: `ST_TRAIL` to `ST_IDLE`, taken at the end of the eighth bit.

Top module: `spi_byte_master`

## Requirements
- R1: Address 0 is the control register. It is read/write, and all eight bits read back as written. The bits are: 7 = interrupt enable, 6 = unit enable, 5 and 4 = stored only, 3 = CPOL, 2 = CPHA, 1:0 = rate code.
- R2: Address 1 is the status register. Bit 7 is the done flag, bit 6 is the collision flag, and bit 4 (fault) and all other bits always read 0. Writes to address 1 have no effect.
- R3: A write to address 2 with the unit enabled and idle starts a transfer. `busy` is high from the next cycle for exactly 16·H cycles, where H = 1, 2, 8 or 16 clocks for rate codes 0, 1, 2 and 3.
- R4: `mosi` carries the written byte MSB first. Each bit is held for 2·H cycles, and `mosi` is 0 while idle.
- R5: `sck` idles at CPOL. During a transfer it equals CPOL xor CPHA xor (1 in the second half of a bit). With CPHA=0 the first bit is on `mosi` before the first `sck` edge; with CPHA=1 `mosi` changes on the first edge of each bit.
- R6: `miso` is sampled at the end of the first half of every bit and shifted in MSB first. The full byte becomes the address-2 read value at the edge where the done flag sets. Address 2 reads as 0 after reset.
- R7: The done flag sets at the same edge where `busy` falls. That completion also drops any armed clear.
- R8: `irq` is high exactly while the done flag and the interrupt enable bit are both 1.
- R9: A write to address 2 while the enable bit is 0 is ignored entirely. It starts nothing, sets no flag and clears no armed flag.
- R10: A write to address 2 with the unit enabled during a transfer sets the collision flag and discards the byte. The transfer in progress continues unchanged.
- R11: A status read records the flags set at that moment (an empty set if none) as the armed set. The next address-2 read, or enabled address-2 write, clears exactly the armed flags and disarms. In the same cycle, a new done or collision event is applied after the clear.
- R12: Reset aborts any transfer. It zeroes the control register, both flags, the armed set and the received byte, so `sck`, `mosi`, `busy` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| miso | input | 1 | Serial data from the slave |
| reg_rdata | output | 8 | Combinational read value of the selected register |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |

## Verification
A wrong state or bit counter shows up on `sck` or `mosi` within one half-period. It also moves the falling edge of `busy` and the rise of the done flag, so it can be seen at the latest by the end of that byte. A wrong capture edge or shifter only appears in the address-2 read value after completion. A wrong armed set only appears at the first status read after the following data access. The bench therefore compares every output on every cycle against a behavioural model, and it exercises each mode and rate, collisions during a transfer, and the armed-clear sequence across a completion.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_e;

    // control register, field order is the bit order 7..0
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       wor_opt;
        logic       master_sel;
        logic       pol;
        logic       pha;
        logic [1:0] rate;
    } ctrl_t;

    localparam int SB_DONE  = 7;
    localparam int SB_COLL  = 6;
    localparam int SB_FAULT = 4;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int HALF_R0 = 1,
    parameter int HALF_R1 = 2,
    parameter int HALF_R2 = 8,
    parameter int HALF_R3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       half_end
);
    localparam int MAX01 = (HALF_R0 > HALF_R1) ? HALF_R0 : HALF_R1;
    localparam int MAX23 = (HALF_R2 > HALF_R3) ? HALF_R2 : HALF_R3;
    localparam int MAXH  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXH) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (rate)
            2'd0:    lim = CNT_W'(HALF_R0 - 1);
            2'd1:    lim = CNT_W'(HALF_R1 - 1);
            2'd2:    lim = CNT_W'(HALF_R2 - 1);
            default: lim = CNT_W'(HALF_R3 - 1);
        endcase
    end

    assign half_end = run && (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || half_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R3: a half-period never ends on the first cycle after a start unless H is 1
    p_no_early_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && lim != '0) |-> !half_end);

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_byte_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              half_end,
    input  logic              pol,
    input  logic              pha,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    xfer_state_e       state, state_n;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              last_bit;

    assign last_bit = (bit_idx == BIT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // transitions: start, capture, advance, finish
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_LEAD;
            ST_LEAD:  if (half_end) state_n = ST_TRAIL;
            ST_TRAIL: if (half_end) state_n = last_bit ? ST_IDLE : ST_LEAD;
            default:  state_n = ST_IDLE;
        endcase
    end

    // shifters and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    tx_sh   <= tx_byte;
                    bit_idx <= '0;
                end
                ST_LEAD: if (half_end)
                    rx_sh <= {rx_sh[DATA_W-2:0], miso};
                ST_TRAIL: if (half_end) begin
                    tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        mosi = tx_sh[DATA_W-1];
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                mosi = 1'b0;
                sck  = pol;
            end
            ST_LEAD:  sck = pol ^ pha;
            ST_TRAIL: begin
                sck  = ~(pol ^ pha);
                done = half_end && last_bit;
            end
            default: begin
                busy = 1'b0;
                mosi = 1'b0;
                sck  = pol;
            end
        endcase
    end

    assign rx_byte = rx_sh;

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(state) == ST_LEAD) |-> $stable(mosi));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_byte_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    input  logic             done,
    input  logic [REG_W-1:0] rx_byte,
    output logic [REG_W-1:0] rdata,
    output logic             irq,
    output logic             start,
    output logic             pol,
    output logic             pha,
    output logic [1:0]       rate
);
    reg_addr_e        a_sel;
    ctrl_t            ctrl;
    logic             flag_done, flag_coll;
    logic             arm_done, arm_coll;
    logic [REG_W-1:0] rx_hold;
    logic             stat_rd, data_rd, data_wr_ok, data_acc, coll;

    assign a_sel      = reg_addr_e'(addr);
    assign stat_rd    = rd && (a_sel == ADDR_STAT);
    assign data_rd    = rd && (a_sel == ADDR_DATA);
    assign data_wr_ok = wr && (a_sel == ADDR_DATA) && ctrl.enable;
    assign data_acc   = data_rd || data_wr_ok;
    assign start      = data_wr_ok && !busy;
    assign coll       = data_wr_ok && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr && a_sel == ADDR_CTRL)
            ctrl <= ctrl_t'(wdata);
    end

    // flags: armed clear first, new events after
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_done <= 1'b0;
            flag_coll <= 1'b0;
        end else begin
            flag_done <= (flag_done && !(data_acc && arm_done)) || done;
            flag_coll <= (flag_coll && !(data_acc && arm_coll)) || coll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_done <= 1'b0;
            arm_coll <= 1'b0;
        end else if (done || data_acc) begin
            arm_done <= 1'b0;
            arm_coll <= 1'b0;
        end else if (stat_rd) begin
            arm_done <= flag_done;
            arm_coll <= flag_coll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_hold <= '0;
        else if (done)
            rx_hold <= rx_byte;
    end

    always_comb begin
        rdata = '0;
        unique case (a_sel)
            ADDR_CTRL: rdata = ctrl;
            ADDR_STAT: begin
                rdata[SB_DONE]  = flag_done;
                rdata[SB_COLL]  = flag_coll;
                rdata[SB_FAULT] = 1'b0;
            end
            ADDR_DATA: rdata = rx_hold;
            ADDR_NONE: rdata = '0;
        endcase
    end

    assign irq  = flag_done && ctrl.irq_en;
    assign pol  = ctrl.pol;
    assign pha  = ctrl.pha;
    assign rate = ctrl.rate;

    p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_done);

    p_coll_keeps_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !done) |=> (busy && flag_coll));

    p_disabled_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && a_sel == ADDR_DATA && !ctrl.enable && !busy) |=> !busy);

    p_armed_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && arm_done && !done) |=> !flag_done);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int HALF_R0 = 1,
    parameter int HALF_R1 = 2,
    parameter int HALF_R2 = 8,
    parameter int HALF_R3 = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             miso,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             busy,
    output logic             sck,
    output logic             mosi
);
    logic             start, done, half_end, pol, pha;
    logic [1:0]       rate;
    logic [REG_W-1:0] rx_byte;

    spi_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .busy    (busy),
        .done    (done),
        .rx_byte (rx_byte),
        .rdata   (reg_rdata),
        .irq     (irq),
        .start   (start),
        .pol     (pol),
        .pha     (pha),
        .rate    (rate)
    );

    spi_rate_div #(
        .HALF_R0 (HALF_R0),
        .HALF_R1 (HALF_R1),
        .HALF_R2 (HALF_R2),
        .HALF_R3 (HALF_R3)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .rate     (rate),
        .half_end (half_end)
    );

    spi_shift_fsm #(.DATA_W(REG_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_byte  (reg_wdata),
        .half_end (half_end),
        .pol      (pol),
        .pha      (pha),
        .miso     (miso),
        .busy     (busy),
        .sck      (sck),
        .mosi     (mosi),
        .done     (done),
        .rx_byte  (rx_byte)
    );

endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic       miso = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq, busy, sck, mosi;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_byte_master u_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .miso(miso),
        .reg_rdata(reg_rdata), .irq(irq), .busy(busy), .sck(sck), .mosi(mosi)
    );

    // ---------------- behavioural reference model ----------------
    int m_ctrl, m_done, m_coll, m_arm_d, m_arm_c, m_busy, m_t, m_tx, m_rx, m_hold;
    int e_h, e_k, e_pre_busy;
    bit e_fin, e_acc, e_st;

    function automatic int half_len(input int code);
        case (code & 3)
            0: return 1;
            1: return 2;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_done = 0; m_coll = 0; m_arm_d = 0; m_arm_c = 0;
            m_busy = 0; m_t = 0; m_tx = 0; m_rx = 0; m_hold = 0;
        end else begin
            e_h = half_len(m_ctrl);
            e_fin = 0;
            e_st = 0;
            e_pre_busy = m_busy;
            e_acc = (reg_rd && reg_addr == 2) ||
                    (reg_wr && reg_addr == 2 && m_ctrl[6]);
            if (m_busy != 0) begin
                e_k = m_t / e_h;
                if ((m_t % e_h) == e_h - 1 && (e_k % 2) == 0)
                    m_rx = ((m_rx << 1) | int'(miso)) & 255;
                if (m_t == 16 * e_h - 1) e_fin = 1;
                m_t++;
            end
            if (reg_rd && reg_addr == 1) begin
                m_arm_d = m_done; m_arm_c = m_coll;
            end
            if (e_acc) begin
                if (m_arm_d != 0) m_done = 0;
                if (m_arm_c != 0) m_coll = 0;
                m_arm_d = 0; m_arm_c = 0;
            end
            if (reg_wr && reg_addr == 2 && m_ctrl[6]) begin
                if (e_pre_busy != 0) m_coll = 1;
                else begin e_st = 1; m_tx = reg_wdata; end
            end
            if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata;
            if (e_fin) begin
                m_done = 1; m_arm_d = 0; m_arm_c = 0; m_hold = m_rx; m_busy = 0;
            end
            if (e_st) begin m_busy = 1; m_t = 0; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    int c_h, c_k, c_pol, c_pha;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            c_h = half_len(m_ctrl);
            c_k = m_t / c_h;
            c_pol = (m_ctrl >> 3) & 1;
            c_pha = (m_ctrl >> 2) & 1;
            chk("R3 busy", int'(busy), m_busy);
            chk("R5 sck", int'(sck), (m_busy != 0) ? (c_pol ^ c_pha ^ (c_k & 1)) : c_pol);
            chk("R4 mosi", int'(mosi), (m_busy != 0) ? ((m_tx >> (7 - c_k / 2)) & 1) : 0);
            chk("R8 irq", int'(irq), m_done & ((m_ctrl >> 7) & 1));
            case (reg_addr)
                2'd0: chk("R1 ctrl read", int'(reg_rdata), m_ctrl);
                2'd1: chk("R2 status read", int'(reg_rdata), (m_done << 7) | (m_coll << 6));
                2'd2: chk("R6 data read", int'(reg_rdata), m_hold);
                default: chk("R2 unmapped read", int'(reg_rdata), 0);
            endcase
        end
    end

    // miso stimulus from an LFSR
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        miso = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(posedge clk); #1;
        reg_addr = 2'(a); reg_rd = 1'b1;
        @(negedge clk);
        chk(tag, int'(reg_rdata), exp);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic peek(input int a, input int exp, input string tag);
        @(posedge clk); #1;
        reg_addr = 2'(a);
        @(negedge clk);
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset sck", int'(sck), 0);
        chk("R12 reset mosi", int'(mosi), 0);
        chk("R12 reset irq", int'(irq), 0);
        chk("R12 reset ctrl", int'(reg_rdata), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        peek(2, 0, "R12 reset data read");
        peek(1, 0, "R12 reset status");

        // R1: all control bits read back, including stored-only bits
        wr(0, 8'h35);
        peek(0, 8'h35, "R1 ctrl readback");
        wr(0, 8'h40);

        // R10 / R7 / R11: collision during a transfer, then clear both
        wr(2, 8'hA5);
        idle(3);
        wr(2, 8'h3C);
        chk("R10 busy after collision", int'(busy), 1);
        wait_idle();
        rd_chk(1, 8'hC0, "R7 done and collision set");
        rd_chk(2, m_hold, "R6 received byte");
        peek(1, 8'h00, "R11 both flags cleared");

        // R7 / R11: completion drops an armed clear
        wr(2, 8'h11);
        wr(2, 8'h22);
        rd_chk(1, 8'h40, "R11 status during transfer");
        wait_idle();
        rd_chk(2, m_hold, "R6 received byte 2");
        peek(1, 8'hC0, "R7 completion disarmed clear");
        rd_chk(1, 8'hC0, "R11 arm both");
        rd_chk(2, m_hold, "R11 clear by data read");
        peek(1, 8'h00, "R11 flags cleared");

        // R11: status read with no flags arms an empty set
        rd_chk(1, 8'h00, "R11 empty arm");
        wr(2, 8'h0F);
        wait_idle();
        rd_chk(2, m_hold, "R11 data read after empty arm");
        peek(1, 8'h80, "R11 done kept after empty arm");
        rd_chk(1, 8'h80, "R11 arm done");
        rd_chk(2, m_hold, "R11 clear done");

        // R3 R4 R5 R8: every mode and rate with the interrupt enabled
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                wr(0, 8'hC0 | (m << 2) | r);
                wr(2, (8'h5A + 37 * (4 * m + r)) & 8'hFF);
                wait_idle();
                @(negedge clk);
                chk("R8 irq after done", int'(irq), 1);
                rd_chk(1, 8'h80, "R7 done flag");
                rd_chk(2, m_hold, "R6 received byte mode");
                @(negedge clk);
                chk("R8 irq after clear", int'(irq), 0);
            end
        end

        // R8: done with interrupt disabled gives no request
        wr(0, 8'h4C);
        wr(2, 8'h99);
        wait_idle();
        @(negedge clk);
        chk("R8 irq masked", int'(irq), 0);

        // R9: disabled write ignored, armed clear survives
        rd_chk(1, 8'h80, "R9 arm done");
        wr(0, 8'h00);
        wr(2, 8'h77);
        @(negedge clk);
        chk("R9 no start when disabled", int'(busy), 0);
        peek(1, 8'h80, "R9 flag not cleared by ignored write");
        wr(0, 8'h40);
        rd_chk(2, m_hold, "R9 armed clear still works");
        peek(1, 8'h00, "R9 flag cleared afterwards");

        // R2: status writes ignored
        wr(1, 8'hFF);
        peek(1, 8'h00, "R2 status write ignored");

        // R12: reset during a transfer
        wr(0, 8'h4B);
        wr(2, 8'hE7);
        idle(5);
        @(posedge clk); #1; rst_n = 1'b0;
        @(negedge clk);
        chk("R12 abort busy", int'(busy), 0);
        chk("R12 abort sck", int'(sck), 0);
        chk("R12 abort mosi", int'(mosi), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        peek(0, 8'h00, "R12 ctrl zeroed");
        peek(1, 8'h00, "R12 flags zeroed");
        idle(4);
        finish_run();
    end

endmodule